// File: doc/BRIEF.md
# Transmit Bank Manager

This block does the bookkeeping for the transmit part of a packet RAM. The region is set up either as one 2 KB buffer that the host and the transmitter use in turn, or as two equal banks used ping-pong. In the ping-pong arrangement the host loads one bank while the transmitter drains the other. The host adds packets to its current fill bank one at a time. Each packet takes a 2-byte length header plus its payload. The block reports, for a length the host presents, whether that packet still fits. The host can keep chaining packets into the bank until one no longer fits.

A commit hands the filled bank to the transmitter. The transmitter then reports each packet it finishes. When the last queued packet of a bank is done, the bank goes back to the host, emptied, and a one-cycle completion pulse is raised. The block also gives the byte address where the next header goes and the base address of the bank being sent, so the data path can find both regions. The block does not move data and does not arbitrate memory access.

Top module: `txbank_mgr`

## Requirements
- R1: After reset the arrangement code is 00, the fill bank is 0, the fill level and packet count are 0, and hst_busy, tx_ready and tx_done are all low.
- R2: The arrangement code gives the bank size and the addresses. 00 means one 2048-byte buffer, 01 means two 2048-byte banks, 10 means two 4096-byte banks and 11 means two 8192-byte banks. Bank b starts at address b times the bank size. fill_addr equals the fill bank base plus the fill level, and tx_addr equals the base of the transmitting bank.
- R3: hst_fits is high exactly when three conditions hold: the fill bank is host-owned, its packet count is below 255, and the fill level plus 2 plus hst_len is at most the bank size.
- R4: A hst_push that fits, with hst_commit low, adds hst_len+2 to the fill level and 1 to the packet count. A push that does not fit, or that comes together with a commit, changes nothing.
- R5: A hst_commit on a host-owned fill bank holding at least one packet gives that bank to the transmitter. tx_pkts then shows its packet count. A commit on an empty bank is ignored.
- R6: In single-buffer mode the fill bank stays bank 0. From a commit until that bank is released, hst_busy is high and hst_fits is low.
- R7: In two-bank mode an accepted commit moves the fill bank to the other bank. hst_busy is high while that bank is still owned by the transmitter.
- R8: Each tx_pkt_done while tx_ready is high lowers tx_pkts by one. tx_pkt_done while tx_ready is low is ignored.
- R9: The tx_pkt_done that finishes the last packet of a bank returns the bank to the host with level 0. On the next cycle tx_done is high for exactly one cycle.
- R10: In two-bank mode the banks are transmitted in the order in which they were committed.
- R11: cfg_wr takes effect only when both banks are host-owned and empty and hst_push is low. Otherwise it is ignored. An accepted change resets both pointers to bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Request to load a new arrangement code |
| cfg_size | input | 2 | New arrangement code |
| cur_size | output | 2 | Arrangement code in force |
| hst_len | input | LEN_W (14) | Payload length of the next packet, in bytes |
| hst_push | input | 1 | Append one packet of hst_len bytes |
| hst_commit | input | 1 | Hand the fill bank to the transmitter |
| hst_fits | output | 1 | The packet of hst_len bytes fits now |
| hst_busy | output | 1 | The fill bank is owned by the transmitter |
| fill_bank | output | 1 | Index of the bank the host fills |
| fill_level | output | LVL_W (14) | Bytes used in the fill bank |
| fill_pkts | output | PKT_W (8) | Packets queued in the fill bank |
| fill_addr | output | ADDR_W (14) | Address of the next header |
| tx_pkt_done | input | 1 | Transmitter finished one packet |
| tx_ready | output | 1 | A bank is waiting for or under transmission |
| tx_bank | output | 1 | Index of the bank being transmitted |
| tx_pkts | output | PKT_W (8) | Packets left in the transmitting bank |
| tx_addr | output | ADDR_W (14) | Base address of the transmitting bank |
| tx_done | output | 1 | One-cycle pulse when a bank has been fully sent |

## Verification
Several properties are checked on every cycle by the assertions. A bank's fill level never exceeds its size. A transmitter-owned bank always holds a packet. Pushes reach only host-owned banks and completions reach only transmitter-owned ones. A busy host never sees a fit. Every tx_done pulse follows a last-packet completion. The arrangement code changes only after an idle, empty cycle. When both banks are queued, the fill pointer sits on the older bank. Other behaviour only the bench scenarios can show: the exact fill arithmetic at the full-bank boundary, a commit on an empty bank being ignored, and ping-pong ordering over long runs. Rejected size changes and the new address bases after an accepted change are also shown there.

// File: rtl/txbank_pkg.sv
// Shared types for the transmit bank manager.
// Assumes: at most two banks; the arrangement code is two bits wide.
package txbank_pkg;
    typedef enum logic {
        OWN_HOST = 1'b0,
        OWN_TX   = 1'b1
    } owner_e;

    typedef enum logic [1:0] {
        SZ_ONE_2K = 2'b00,
        SZ_TWO_2K = 2'b01,
        SZ_TWO_4K = 2'b10,
        SZ_TWO_8K = 2'b11
    } size_e;
endpackage

// File: rtl/txbank_geom.sv
// Decodes the arrangement code into the bank mode and the bank size in bytes.
// Assumes: the largest bank (BASE_BYTES*4) can be represented in LVL_W bits.
module txbank_geom #(
    parameter int BASE_BYTES = 2048,
    parameter int LVL_W      = 14
) (
    input  logic [1:0]       size,
    output logic             dual,
    output logic [LVL_W-1:0] cap
);
    import txbank_pkg::*;

    localparam logic [LVL_W-1:0] CAP1 = LVL_W'(BASE_BYTES);

    // Map the code to a mode and a power-of-two multiple of the base size.
    always_comb begin
        dual = 1'b1;
        cap  = CAP1;
        case (size_e'(size))
            SZ_ONE_2K: begin dual = 1'b0; cap = CAP1;       end
            SZ_TWO_2K: begin dual = 1'b1; cap = CAP1;       end
            SZ_TWO_4K: begin dual = 1'b1; cap = CAP1 << 1;  end
            default:   begin dual = 1'b1; cap = CAP1 << 2;  end
        endcase
    end
endmodule

// File: rtl/txbank_space.sv
// Space check: says whether a packet of len payload bytes plus its header
// still fits in the fill bank, and how many bytes that packet occupies.
// Assumes: need_bytes is meaningful only when fits is high.
module txbank_space #(
    parameter int LVL_W     = 14,
    parameter int LEN_W     = 14,
    parameter int PKT_W     = 8,
    parameter int HDR_BYTES = 2
) (
    input  logic [LVL_W-1:0] cap,
    input  logic [LVL_W-1:0] level,
    input  logic [PKT_W-1:0] pkts,
    input  logic             host_own,
    input  logic [LEN_W-1:0] len,
    output logic             fits,
    output logic [LVL_W-1:0] need_bytes
);
    localparam int SUM_W = ((LVL_W > LEN_W) ? LVL_W : LEN_W) + 2;

    logic [SUM_W-1:0] need_w;
    logic [SUM_W-1:0] total_w;

    // Bytes the packet needs, and the level the bank would reach after it.
    always_comb begin
        need_w     = SUM_W'(len) + SUM_W'(HDR_BYTES);
        total_w    = SUM_W'(level) + need_w;
        need_bytes = LVL_W'(need_w);
        fits       = host_own && (pkts != {PKT_W{1'b1}}) && (total_w <= SUM_W'(cap));
    end
endmodule

// File: rtl/txbank_bank.sv
// State of one bank: its owner, its fill level and its queued packet count.
// Host pushes grow it, a commit hands it to the transmitter, and each
// transmitter step drains one packet. The last step clears it back to the host.
// Assumes: the caller enables at most push or commit, and only for the right owner.
module txbank_bank #(
    parameter int LVL_W = 14,
    parameter int PKT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LVL_W-1:0]     cap,
    input  logic                 push_en,
    input  logic [LVL_W-1:0]     push_bytes,
    input  logic                 commit_en,
    input  logic                 step_en,
    output txbank_pkg::owner_e   owner,
    output logic [LVL_W-1:0]     level,
    output logic [PKT_W-1:0]     pkts,
    output logic                 last_out
);
    import txbank_pkg::*;

    localparam logic [PKT_W-1:0] ONE = PKT_W'(1);

    // Flag the step that drains the final packet.
    assign last_out = step_en && (pkts == ONE);

    // Update ownership, level and count for one bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= OWN_HOST;
            level <= '0;
            pkts  <= '0;
        end else if (step_en) begin
            if (pkts == ONE) begin
                owner <= OWN_HOST;
                level <= '0;
                pkts  <= '0;
            end else begin
                pkts <= pkts - ONE;
            end
        end else if (commit_en) begin
            owner <= OWN_TX;
        end else if (push_en) begin
            level <= level + push_bytes;
            pkts  <= pkts + ONE;
        end
    end

    assert_level_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap);

    assert_tx_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_TX) |-> (pkts != '0));

    assert_push_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (owner == OWN_HOST));

    assert_step_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (owner == OWN_TX));
endmodule

// File: rtl/txbank_mgr.sv
// Transmit bank manager top. It holds the arrangement code, the fill and
// transmit bank pointers and the completion pulse, and it routes host and
// transmitter events to the two bank instances.
// Assumes: bank 1 stays unused and empty in single-buffer mode.
module txbank_mgr #(
    parameter int BASE_BYTES = 2048,
    parameter int HDR_BYTES  = 2,
    parameter int LEN_W      = 14,
    parameter int PKT_W      = 8,
    localparam int MAX_BYTES = BASE_BYTES * 4,
    localparam int LVL_W     = $clog2(MAX_BYTES + 1),
    localparam int ADDR_W    = $clog2(2 * MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_size,
    output logic [1:0]        cur_size,
    input  logic [LEN_W-1:0]  hst_len,
    input  logic              hst_push,
    input  logic              hst_commit,
    output logic              hst_fits,
    output logic              hst_busy,
    output logic              fill_bank,
    output logic [LVL_W-1:0]  fill_level,
    output logic [PKT_W-1:0]  fill_pkts,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              tx_pkt_done,
    output logic              tx_ready,
    output logic              tx_bank,
    output logic [PKT_W-1:0]  tx_pkts,
    output logic [ADDR_W-1:0] tx_addr,
    output logic              tx_done
);
    import txbank_pkg::*;

    localparam int NBANK = 2;

    logic [1:0]       size_q;
    logic             fill_sel;
    logic             tx_sel;
    logic             done_q;
    logic             dual;
    logic [LVL_W-1:0] cap;
    logic [LVL_W-1:0] need_bytes;
    logic             host_ok;
    logic             push_ok;
    logic             commit_ok;
    logic             step_ok;
    logic             idle_all;
    logic             cfg_ok;
    logic             any_last;

    owner_e           own   [NBANK];
    logic [LVL_W-1:0] lvl   [NBANK];
    logic [PKT_W-1:0] pk    [NBANK];
    logic             last  [NBANK];

    txbank_geom #(
        .BASE_BYTES (BASE_BYTES),
        .LVL_W      (LVL_W)
    ) u_geom (
        .size (size_q),
        .dual (dual),
        .cap  (cap)
    );

    txbank_space #(
        .LVL_W     (LVL_W),
        .LEN_W     (LEN_W),
        .PKT_W     (PKT_W),
        .HDR_BYTES (HDR_BYTES)
    ) u_space (
        .cap        (cap),
        .level      (lvl[fill_sel]),
        .pkts       (pk[fill_sel]),
        .host_own   (host_ok),
        .len        (hst_len),
        .fits       (hst_fits),
        .need_bytes (need_bytes)
    );

    // Qualify host, transmitter and configuration events.
    always_comb begin
        host_ok   = (own[fill_sel] == OWN_HOST);
        commit_ok = hst_commit && host_ok && (pk[fill_sel] != '0);
        push_ok   = hst_push && !hst_commit && hst_fits;
        tx_ready  = (own[tx_sel] == OWN_TX);
        step_ok   = tx_pkt_done && tx_ready;
        idle_all  = (own[0] == OWN_HOST) && (own[1] == OWN_HOST) &&
                    (pk[0] == '0) && (pk[1] == '0) &&
                    (lvl[0] == '0) && (lvl[1] == '0);
        cfg_ok    = cfg_wr && idle_all && !hst_push;
        any_last  = last[0] || last[1];
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        txbank_bank #(
            .LVL_W (LVL_W),
            .PKT_W (PKT_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cap        (cap),
            .push_en    (push_ok && (fill_sel == 1'(g))),
            .push_bytes (need_bytes),
            .commit_en  (commit_ok && (fill_sel == 1'(g))),
            .step_en    (step_ok && (tx_sel == 1'(g))),
            .owner      (own[g]),
            .level      (lvl[g]),
            .pkts       (pk[g]),
            .last_out   (last[g])
        );
    end

    // Hold the arrangement code; accept a new one only when fully idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      size_q <= 2'b00;
        else if (cfg_ok) size_q <= cfg_size;
    end

    // Advance the fill pointer to the other bank after each accepted commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fill_sel <= 1'b0;
        else if (cfg_ok)            fill_sel <= 1'b0;
        else if (commit_ok && dual) fill_sel <= ~fill_sel;
    end

    // Advance the transmit pointer once a bank is fully drained.
    always_ff @(posedge clk) begin
        if (!rst_n)                           tx_sel <= 1'b0;
        else if (cfg_ok)                      tx_sel <= 1'b0;
        else if (step_ok && any_last && dual) tx_sel <= ~tx_sel;
    end

    // Register the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= step_ok && any_last;
    end

    // Drive the status and address outputs.
    always_comb begin
        cur_size   = size_q;
        hst_busy   = !host_ok;
        fill_bank  = fill_sel;
        fill_level = lvl[fill_sel];
        fill_pkts  = pk[fill_sel];
        fill_addr  = (fill_sel ? ADDR_W'(cap) : '0) + ADDR_W'(lvl[fill_sel]);
        tx_bank    = tx_sel;
        tx_pkts    = tx_ready ? pk[tx_sel] : '0;
        tx_addr    = tx_sel ? ADDR_W'(cap) : '0;
        tx_done    = done_q;
    end

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(tx_pkt_done && tx_ready && (tx_pkts == PKT_W'(1))));

    assert_busy_nofit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hst_busy |-> !hst_fits);

    assert_single_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_size == 2'b00) |-> (!fill_bank && !tx_bank && (own[1] == OWN_HOST)));

    assert_cfg_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_size != $past(cur_size)) |-> $past(idle_all && !hst_push));

    assert_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((own[0] == OWN_TX) && (own[1] == OWN_TX)) |-> (fill_bank == tx_bank));
endmodule

// File: tb/txbank_mgr_tb.sv
`timescale 1ns/1ps
module txbank_mgr_tb;
    localparam int LEN_W = 14;
    localparam int PKT_W = 8;
    localparam int LVL_W = 14;
    localparam int ADDR_W = 14;
    localparam int MAXPK = 255;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_size = 2'b00;
    logic [1:0]        cur_size;
    logic [LEN_W-1:0]  hst_len = '0;
    logic              hst_push = 1'b0;
    logic              hst_commit = 1'b0;
    logic              hst_fits;
    logic              hst_busy;
    logic              fill_bank;
    logic [LVL_W-1:0]  fill_level;
    logic [PKT_W-1:0]  fill_pkts;
    logic [ADDR_W-1:0] fill_addr;
    logic              tx_pkt_done = 1'b0;
    logic              tx_ready;
    logic              tx_bank;
    logic [PKT_W-1:0]  tx_pkts;
    logic [ADDR_W-1:0] tx_addr;
    logic              tx_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference state, derived from the requirements.
    int m_size, m_fs, m_ts, m_done;
    int m_own[2];
    int m_lvl[2];
    int m_pk[2];

    always #2.5 clk = ~clk;

    txbank_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size(cfg_size),
        .cur_size(cur_size), .hst_len(hst_len), .hst_push(hst_push),
        .hst_commit(hst_commit), .hst_fits(hst_fits), .hst_busy(hst_busy),
        .fill_bank(fill_bank), .fill_level(fill_level), .fill_pkts(fill_pkts),
        .fill_addr(fill_addr), .tx_pkt_done(tx_pkt_done), .tx_ready(tx_ready),
        .tx_bank(tx_bank), .tx_pkts(tx_pkts), .tx_addr(tx_addr), .tx_done(tx_done)
    );

    function automatic int mcap(int s);
        return (s == 0) ? 2048 : (2048 << (s - 1));
    endfunction

    function automatic bit mfits(int len);
        return (m_own[m_fs] == 0) && (m_pk[m_fs] < MAXPK) &&
               (m_lvl[m_fs] + 2 + len <= mcap(m_size));
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_size = 0; m_fs = 0; m_ts = 0; m_done = 0;
        for (int b = 0; b < 2; b++) begin
            m_own[b] = 0; m_lvl[b] = 0; m_pk[b] = 0;
        end
    endtask

    // One cycle of stimulus: predict, clock, compare.
    task automatic step(bit push, int len, bit commit, bit txd, bit cfgw, int cfgv);
        bit fit, host_ok, txr, dual, idle;
        @(negedge clk);
        hst_push = push; hst_len = LEN_W'(len); hst_commit = commit;
        tx_pkt_done = txd; cfg_wr = cfgw; cfg_size = 2'(cfgv);
        #1;
        fit = mfits(len);
        chk("R3", "hst_fits", int'(hst_fits), int'(fit));
        host_ok = (m_own[m_fs] == 0);
        txr = (m_own[m_ts] == 1);
        dual = (m_size != 0);
        idle = (m_own[0] == 0) && (m_own[1] == 0) && (m_pk[0] == 0) &&
               (m_pk[1] == 0) && (m_lvl[0] == 0) && (m_lvl[1] == 0);
        m_done = 0;
        if (cfgw && idle && !push) begin
            m_size = cfgv; m_fs = 0; m_ts = 0;
        end else begin
            if (txr && txd) begin
                if (m_pk[m_ts] == 1) begin
                    m_own[m_ts] = 0; m_lvl[m_ts] = 0; m_pk[m_ts] = 0; m_done = 1;
                    if (dual) m_ts = 1 - m_ts;
                end else begin
                    m_pk[m_ts]--;
                end
            end
            if (commit) begin
                if (host_ok && m_pk[m_fs] > 0) begin
                    m_own[m_fs] = 1;
                    if (dual) m_fs = 1 - m_fs;
                end
            end else if (push && fit) begin
                m_lvl[m_fs] += len + 2;
                m_pk[m_fs]++;
            end
        end
        @(posedge clk);
        #1;
        chk("R11", "cur_size", int'(cur_size), m_size);
        chk("R7", "fill_bank", int'(fill_bank), m_fs);
        chk("R4", "fill_level", int'(fill_level), m_lvl[m_fs]);
        chk("R4", "fill_pkts", int'(fill_pkts), m_pk[m_fs]);
        chk("R2", "fill_addr", int'(fill_addr), m_fs * mcap(m_size) + m_lvl[m_fs]);
        chk("R6", "hst_busy", int'(hst_busy), m_own[m_fs]);
        chk("R5", "tx_ready", int'(tx_ready), m_own[m_ts]);
        chk("R10", "tx_bank", int'(tx_bank), m_ts);
        chk("R8", "tx_pkts", int'(tx_pkts), (m_own[m_ts] == 1) ? m_pk[m_ts] : 0);
        chk("R9", "tx_done", int'(tx_done), m_done);
        chk("R2", "tx_addr", int'(tx_addr), m_ts * mcap(m_size));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "cur_size", int'(cur_size), 0);
        chk("R1", "fill_bank", int'(fill_bank), 0);
        chk("R1", "fill_level", int'(fill_level), 0);
        chk("R1", "fill_pkts", int'(fill_pkts), 0);
        chk("R1", "hst_busy", int'(hst_busy), 0);
        chk("R1", "tx_ready", int'(tx_ready), 0);
        chk("R1", "tx_done", int'(tx_done), 0);

        // R5: commit of an empty bank is ignored
        step(0, 0, 1, 0, 0, 0);
        // R6: single buffer, push, commit, host blocked until drained
        step(1, 100, 0, 0, 0, 0);
        step(1, 50, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(1, 10, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        // R11: change to two 2K banks while idle
        step(0, 0, 0, 0, 1, 1);
        // R3/R4: exact fill of a 2K bank, then one more byte fails
        step(1, 2046, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        // R7: commit moves fill to bank 1
        step(0, 0, 1, 0, 0, 0);
        step(1, 300, 1, 0, 0, 0);
        step(1, 300, 0, 0, 0, 0);
        // R7: second commit lands on bank 0, which is still queued: busy
        step(0, 0, 1, 0, 0, 0);
        // R11: change rejected while banks are queued
        step(0, 0, 0, 0, 1, 3);
        // R9/R10: drain bank 0 then bank 1
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        // R2: two 8K banks; bank 1 base becomes 8192
        step(0, 0, 0, 0, 1, 3);
        step(1, 8190, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1, 2);

        // Constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            bit p, c, t, w;
            int len, sz;
            p = ($urandom_range(0, 99) < 40);
            c = !p && ($urandom_range(0, 99) < 12);
            t = ($urandom_range(0, 99) < 35);
            w = ($urandom_range(0, 99) < 6);
            len = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 700) : $urandom_range(0, 9000);
            sz = $urandom_range(0, 3);
            step(p, len, c, t, w, sz);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule